// File: doc/BRIEF.md
# Reversible LFSR Step Counter

This block is a 15-bit linear feedback shift register used as a compact counter in place of a binary incrementer or decrementer. A direction input selects whether each enabled clock moves the register one position forward or one position backward along its maximal-length sequence. A backward step exactly undoes a forward step, so stepping backward counts down in sequence position.

The register steps only while enable is high. It can be preloaded with any value. A zero load is replaced by a fixed nonzero seed, so the register never leaves the sequence. States are not visited in numeric order. A compare input is matched against the current state. This lets a user count a known number of positions from a loaded start and see when a target position is reached.

Top module: `lfsr_step_counter`

## Requirements
- R1: After reset (rstN low) the state equals the seed 15'h0001.
- R2: With enable=1, dirDown=0 and no load, the next state is the old state shifted left by one, with bit14 XOR bit13 of the old state inserted at bit0.
- R3: With enable=1, dirDown=1 and no load, the next state is the old state shifted right by one, with bit0 XOR bit14 of the old state inserted at bit14.
- R4: A forward step followed by a backward step returns exactly the state held before the two steps.
- R5: With enable=0 and no load, the state does not change.
- R6: Load has priority over stepping. With loadEn=1 the next state is loadVal, whatever enable and dirDown are.
- R7: A load of 15'h0000 gives the seed 15'h0001.
- R8: From the seed, the state first returns to the seed after exactly 32767 forward steps. The same number of backward steps also returns it to the seed.
- R9: The state is never all zeros after reset.
- R10: match is high in the same cycle in which state equals cmpVal, and low otherwise. It is decoded combinationally from the held state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Step the register this cycle |
| dirDown | input | 1 | 0 = forward step, 1 = backward step |
| loadEn | input | 1 | Load loadVal (priority over stepping) |
| loadVal | input | 15 | Value to load; zero is replaced by the seed |
| cmpVal | input | 15 | Compare value for match |
| state | output | 15 | Current register state |
| match | output | 1 | High while state equals cmpVal |

## Verification
On every cycle the assertions check that the state is never zero, that it holds while idle, that a nonzero load lands unchanged, and that the control raises at most one strobe. They also check that the backward function undoes the forward function for the live state. The full 32767-step period, with no early return to the seed, and the backward walk that retraces the same sequence in reverse can only be shown by the bench's long scenario against its own model. The priority of load over stepping, and the match output, are also shown only in the bench's scenarios.

// File: rtl/lfsr_step_pkg.sv
package lfsr_step_pkg;

  // Strobes passed from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic doLoad;
    logic stepFwd;
    logic stepRev;
  } stepStrobes_t;

endpackage

// File: rtl/lfsr_step_ctrl.sv
module lfsr_step_ctrl
  import lfsr_step_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         dirDown,
  input  logic         loadEn,
  output stepStrobes_t strobes
);

  always_comb begin
    strobes         = '0;
    strobes.doLoad  = loadEn;
    strobes.stepFwd = !loadEn && enable && !dirDown;
    strobes.stepRev = !loadEn && enable && dirDown;
  end

  // R6: load and stepping never go to the datapath together
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.doLoad, strobes.stepFwd, strobes.stepRev}));

endmodule

// File: rtl/lfsr_step_dp.sv
module lfsr_step_dp
  import lfsr_step_pkg::*;
#(
  parameter int          WIDTH = 15,
  parameter int          TAP   = 13,
  parameter logic [14:0] SEED  = 15'h0001
)(
  input  logic             clk,
  input  logic             rstN,
  input  stepStrobes_t     strobes,
  input  logic [WIDTH-1:0] loadVal,
  input  logic [WIDTH-1:0] cmpVal,
  output logic [WIDTH-1:0] state,
  output logic             match
);

  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] SEED_W = SEED[WIDTH-1:0];

  // Forward: shift toward MSB, feedback from MSB and TAP into bit 0.
  function automatic logic [WIDTH-1:0] fwdOf(input logic [WIDTH-1:0] s);
    return {s[MSB-1:0], s[MSB] ^ s[TAP]};
  endfunction

  // Reverse: shift toward LSB, rebuild the lost MSB from bit 0 and old MSB
  // (old MSB was the old TAP+1 bit before the forward shift).
  function automatic logic [WIDTH-1:0] revOf(input logic [WIDTH-1:0] s);
    return {s[0] ^ s[TAP+1], s[MSB:1]};
  endfunction

  logic [WIDTH-1:0] nextState;
  logic [WIDTH-1:0] loadSafe;

  assign loadSafe = (loadVal == '0) ? SEED_W : loadVal;

  always_comb begin
    nextState = state;
    if (strobes.doLoad)       nextState = loadSafe;
    else if (strobes.stepFwd) nextState = fwdOf(state);
    else if (strobes.stepRev) nextState = revOf(state);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEED_W;
    else       state <= nextState;
  end

  assign match = (state == cmpVal);

  // R9: the register never reaches the lock-up state
  a_r9_never_zero: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

  // R5: no strobe means the state is held
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.doLoad || strobes.stepFwd || strobes.stepRev) |=> $stable(state));

  // R6: a nonzero load appears unchanged one cycle later
  a_r6_load: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doLoad && loadVal != '0) |=> state == $past(loadVal));

  // R4: backward step undoes forward step for the live state
  always_comb begin
    if (rstN) a_r4_round_trip: assert (revOf(fwdOf(state)) == state);
  end

endmodule

// File: rtl/lfsr_step_counter.sv
module lfsr_step_counter
  import lfsr_step_pkg::*;
#(
  parameter int          WIDTH = 15,
  parameter int          TAP   = 13,
  parameter logic [14:0] SEED  = 15'h0001
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             dirDown,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadVal,
  input  logic [WIDTH-1:0] cmpVal,
  output logic [WIDTH-1:0] state,
  output logic             match
);

  stepStrobes_t strobes;

  lfsr_step_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .dirDown (dirDown),
    .loadEn  (loadEn),
    .strobes (strobes)
  );

  lfsr_step_dp #(
    .WIDTH (WIDTH),
    .TAP   (TAP),
    .SEED  (SEED)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .loadVal (loadVal),
    .cmpVal  (cmpVal),
    .state   (state),
    .match   (match)
  );

endmodule

// File: tb/tb_lfsr_step_counter.sv
module tb_lfsr_step_counter;

  localparam int W = 15;
  localparam int PERIOD = 32767;
  localparam logic [W-1:0] SEED = 15'h0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic dirDown = 1'b0;
  logic loadEn = 1'b0;
  logic [W-1:0] loadVal = '0;
  logic [W-1:0] cmpVal = '0;
  logic [W-1:0] state;
  logic match;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lfsr_step_counter dut (
    .clk(clk), .rstN(rstN), .enable(enable), .dirDown(dirDown),
    .loadEn(loadEn), .loadVal(loadVal), .cmpVal(cmpVal),
    .state(state), .match(match)
  );

  function automatic logic [W-1:0] modelFwd(input logic [W-1:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction
  function automatic logic [W-1:0] modelRev(input logic [W-1:0] s);
    return {s[0] ^ s[14], s[14:1]};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {req, loadEn, enable, dirDown, loadVal, expected state}
  typedef struct packed {
    logic [7:0]   req;
    logic         ld;
    logic         en;
    logic         dn;
    logic [W-1:0] val;
    logic [W-1:0] exp;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{8'd6,  1'b1, 1'b0, 1'b0, 15'h6000, 15'h6000}, // R6 load
    '{8'd2,  1'b0, 1'b1, 1'b0, 15'h0000, 15'h4000}, // R2 forward
    '{8'd2,  1'b0, 1'b1, 1'b0, 15'h0000, 15'h0001}, // R2 forward, feedback 1
    '{8'd5,  1'b0, 1'b0, 1'b1, 15'h7FFF, 15'h0001}, // R5 idle hold
    '{8'd3,  1'b0, 1'b1, 1'b1, 15'h0000, 15'h4000}, // R3 backward
    '{8'd3,  1'b0, 1'b1, 1'b1, 15'h0000, 15'h6000}, // R3 backward, R4 back home
    '{8'd7,  1'b1, 1'b1, 1'b1, 15'h0000, 15'h0001}, // R7 zero load gives seed
    '{8'd6,  1'b1, 1'b1, 1'b0, 15'h1234, 15'h1234}, // R6 load beats step
    '{8'd2,  1'b0, 1'b1, 1'b0, 15'h0000, 15'h2468}, // R2
    '{8'd2,  1'b0, 1'b1, 1'b0, 15'h0000, 15'h48D1}, // R2
    '{8'd4,  1'b0, 1'b1, 1'b1, 15'h0000, 15'h2468}  // R4 undo
  };

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [W-1:0] model;
    bit seqBad;
    bit earlyReturn;
    // R1 reset value
    @(negedge clk);
    check("R1", state, SEED);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", state, SEED);

    foreach (VECS[i]) begin
      loadEn = VECS[i].ld; enable = VECS[i].en; dirDown = VECS[i].dn;
      loadVal = VECS[i].val;
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), state, VECS[i].exp);
    end
    loadEn = 1'b0; enable = 1'b0;

    // R10 match
    cmpVal = state;
    #1 check("R10 match high", {14'd0, match}, 15'd1);
    cmpVal = state ^ 15'h0100;
    #1 check("R10 match low", {14'd0, match}, 15'd0);

    // R8 full period forward from seed
    loadEn = 1'b1; loadVal = SEED;
    @(negedge clk);
    loadEn = 1'b0; enable = 1'b1; dirDown = 1'b0;
    model = SEED; seqBad = 0; earlyReturn = 0;
    for (int k = 1; k <= PERIOD; k++) begin
      @(negedge clk);
      model = modelFwd(model);
      if (state !== model) seqBad = 1;
      if (k < PERIOD && state == SEED) earlyReturn = 1;
      if (state == '0) seqBad = 1;
    end
    check("R8 forward sequence", {14'd0, seqBad}, 15'd0);
    check("R8 no early return", {14'd0, earlyReturn}, 15'd0);
    check("R8 period end", state, SEED);

    // R8/R3 full period backward retraces the sequence
    dirDown = 1'b1; model = SEED; seqBad = 0;
    for (int k = 1; k <= PERIOD; k++) begin
      @(negedge clk);
      model = modelRev(model);
      if (state !== model) seqBad = 1;
    end
    check("R8 backward sequence", {14'd0, seqBad}, 15'd0);
    check("R8 backward end", state, SEED);

    // R4 round trip from an arbitrary state
    enable = 1'b0; loadEn = 1'b1; loadVal = 15'h5A3C;
    @(negedge clk);
    loadEn = 1'b0; enable = 1'b1; dirDown = 1'b0;
    @(negedge clk);
    check("R4 fwd", state, modelFwd(15'h5A3C));
    dirDown = 1'b1;
    @(negedge clk);
    check("R4 round trip", state, 15'h5A3C);
    enable = 1'b0;

    // R1 reset in mid-run
    rstN = 1'b0;
    #1 check("R1 async reset", state, SEED);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    finish();
  end

endmodule